// File: doc/BRIEF.md
# Center Period Calibration Loop

This block holds the average period of a bit-rate oscillator at a programmed value. The oscillator edge arrives as a one-cycle strobe in the reference clock domain. The block counts reference cycles across a window of a fixed number of oscillator periods. It compares that count with a target and moves a digital control code up or down. That code would drive the center-frequency DAC of the oscillator. A larger code is taken to mean a shorter oscillator period. A count above target therefore raises the code, and a count below target lowers it.

The target is a nominal count plus a 9-bit offset, which a host writes through a one-cycle write strobe. The loop runs in two modes. After reset, and after every offset write, it is in fast acquisition mode. In that mode it takes a wide step on each completed window, for exactly 64 windows. It then drops to tracking mode, which takes a single-unit step once every `SLOW_DIV` windows. Steps this rare leave per-bit period modulation elsewhere free to act without interference. A loop-off input freezes the control code. It also freezes the mode counters.

Top module: `cal_center_loop`

## Requirements
- R1: After reset, `ctrl_code_o` equals `CODE_INIT`, `fast_acq_o` is 1, and the offset is 0.
- R2: The first oscillator strobe after reset or after an offset write only arms the measurement. Each later run of `WIN_PERIODS` strobes closes a window. Its count is the number of reference cycles since the previous window edge. In fast mode a closed window moves the code by `FAST_STEP` in the cycle after the closing strobe: up if count > target, down if count < target.
- R3: Fast mode covers exactly 64 counted windows. `fast_acq_o` falls in the cycle after the 64th, and that window still applies a fast step.
- R4: The code saturates at 0 and at 2^`CODE_W`-1. It never wraps.
- R5: In tracking mode every `SLOW_DIV`-th closed window moves the code by exactly 1. The other windows leave it unchanged.
- R6: A window whose count equals the target leaves the code unchanged, but it still counts toward fast mode or the tracking divider.
- R7: An offset write sets target = `NOM_COUNT` + offset. It restarts fast mode with a fresh 64-window budget, raises `fast_acq_o` in the next cycle, and discards any partial window.
- R8: While `loop_off_i` is 1, closed windows change neither the code nor the fast-mode or divider counts.
- R9: If an offset write lands in the same cycle as a window-closing strobe, the write wins. No step is applied, and measurement re-arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle strobe per oscillator period, already synchronized |
| ofs_wr_i | input | 1 | Offset write strobe |
| ofs_data_i | input | OFS_W | Offset write data, unsigned |
| loop_off_i | input | 1 | Freezes code and mode counters |
| ctrl_code_o | output | CODE_W | Control code for the center-frequency DAC |
| fast_acq_o | output | 1 | High during fast acquisition |

## Verification
Two functions can fall in the same cycle: an offset write that restarts acquisition, and the strobe that closes a window and would step the code. The bench provokes this overlap by issuing the write in the exact cycle of the closing strobe, in the middle of fast mode. It then checks that the code kept its value and that `fast_acq_o` stayed high. Last, it counts a full fresh set of 64 windows before `fast_acq_o` falls, which shows that the budget was restarted rather than continued.

// File: rtl/cal_loop_pkg.sv
package cal_loop_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/cal_window_meter.sv
module cal_window_meter #(
  parameter int WIN_PERIODS = 571,
  parameter int CNT_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             osc_tick_i,
  output logic             done_o,
  output logic [CNT_W-1:0] meas_o
);
  localparam int TICK_W = (WIN_PERIODS > 1) ? $clog2(WIN_PERIODS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(WIN_PERIODS - 1);

  logic              armed_q;
  logic [TICK_W-1:0] tick_q;
  logic [CNT_W-1:0]  ref_q;
  logic [CNT_W-1:0]  ref_inc;
  logic              last_tick;

  assign ref_inc   = (ref_q == '1) ? ref_q : ref_q + 1'b1;
  assign last_tick = (tick_q == TICK_LAST);
  assign done_o    = armed_q && osc_tick_i && last_tick && !restart_i;
  assign meas_o    = ref_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      tick_q  <= '0;
      ref_q   <= '0;
    end else if (restart_i) begin
      armed_q <= 1'b0;
      tick_q  <= '0;
      ref_q   <= '0;
    end else if (!armed_q) begin
      if (osc_tick_i) begin
        armed_q <= 1'b1;
        tick_q  <= '0;
        ref_q   <= '0;
      end
    end else if (osc_tick_i) begin
      if (last_tick) begin
        tick_q <= '0;
        ref_q  <= '0;
      end else begin
        tick_q <= tick_q + 1'b1;
        ref_q  <= ref_inc;
      end
    end else begin
      ref_q <= ref_inc;
    end
  end
endmodule

// File: rtl/cal_rate_sched.sv
module cal_rate_sched #(
  parameter int SLOW_DIV    = 16,
  parameter int ACQ_UPDATES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic win_done_i,
  input  logic hold_i,
  output logic step_en_o,
  output logic fast_o
);
  localparam int ACQ_W = (ACQ_UPDATES > 1) ? $clog2(ACQ_UPDATES) : 1;
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [ACQ_W-1:0] ACQ_LAST = ACQ_W'(ACQ_UPDATES - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  logic             fast_q;
  logic [ACQ_W-1:0] acq_q;
  logic [DIV_W-1:0] div_q;
  logic             win_ok;

  assign win_ok    = win_done_i && !hold_i;
  assign step_en_o = win_ok && (fast_q || (div_q == DIV_LAST));
  assign fast_o    = fast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= 1'b1;
      acq_q  <= '0;
      div_q  <= '0;
    end else if (restart_i) begin
      fast_q <= 1'b1;
      acq_q  <= '0;
      div_q  <= '0;
    end else if (win_ok) begin
      if (fast_q) begin
        if (acq_q == ACQ_LAST) begin
          fast_q <= 1'b0;
          acq_q  <= '0;
        end else begin
          acq_q <= acq_q + 1'b1;
        end
      end else begin
        div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_code_stepper.sv
module cal_code_stepper
  import cal_loop_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int CODE_INIT = 128,
  parameter int FAST_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  step_dir_e         dir_i,
  input  logic              fast_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W:0] CODE_MAX = {1'b0, {CODE_W{1'b1}}};

  logic [CODE_W-1:0] code_q;
  logic [CODE_W:0]   step;
  logic [CODE_W:0]   up_sum;
  logic [CODE_W-1:0] code_nxt;

  assign step   = fast_i ? (CODE_W+1)'(FAST_STEP) : (CODE_W+1)'(1);
  assign up_sum = {1'b0, code_q} + step;

  always_comb begin
    code_nxt = code_q;
    unique case (dir_i)
      DIR_UP:   code_nxt = (up_sum > CODE_MAX) ? CODE_MAX[CODE_W-1:0] : up_sum[CODE_W-1:0];
      DIR_DOWN: code_nxt = ({1'b0, code_q} < step) ? '0 : code_q - step[CODE_W-1:0];
      default:  code_nxt = code_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CODE_W'(CODE_INIT);
    else if (step_en_i) code_q <= code_nxt;
  end

  assign code_o = code_q;
endmodule

// File: rtl/cal_center_loop.sv
module cal_center_loop
  import cal_loop_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int CODE_INIT   = 128,
  parameter int FAST_STEP   = 4,
  parameter int OFS_W       = 9,
  parameter int CNT_W       = 16,
  parameter int NOM_COUNT   = 5600,
  parameter int WIN_PERIODS = 571,
  parameter int SLOW_DIV    = 16,
  parameter int ACQ_UPDATES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_tick_i,
  input  logic              ofs_wr_i,
  input  logic [OFS_W-1:0]  ofs_data_i,
  input  logic              loop_off_i,
  output logic [CODE_W-1:0] ctrl_code_o,
  output logic              fast_acq_o
);
  logic [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] meas;
  logic             win_done;
  logic             step_en;
  step_dir_e        dir;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ofs_q <= '0;
    else if (ofs_wr_i) ofs_q <= ofs_data_i;
  end

  assign target = CNT_W'(NOM_COUNT) + CNT_W'(ofs_q);

  // count above target means period too long: raise code
  always_comb begin
    if (meas > target)      dir = DIR_UP;
    else if (meas < target) dir = DIR_DOWN;
    else                    dir = DIR_HOLD;
  end

  cal_window_meter #(
    .WIN_PERIODS(WIN_PERIODS),
    .CNT_W      (CNT_W)
  ) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ofs_wr_i),
    .osc_tick_i(osc_tick_i),
    .done_o    (win_done),
    .meas_o    (meas)
  );

  cal_rate_sched #(
    .SLOW_DIV   (SLOW_DIV),
    .ACQ_UPDATES(ACQ_UPDATES)
  ) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ofs_wr_i),
    .win_done_i(win_done),
    .hold_i    (loop_off_i),
    .step_en_o (step_en),
    .fast_o    (fast_acq_o)
  );

  cal_code_stepper #(
    .CODE_W   (CODE_W),
    .CODE_INIT(CODE_INIT),
    .FAST_STEP(FAST_STEP)
  ) u_stepper (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_en_i(step_en),
    .dir_i    (dir),
    .fast_i   (fast_acq_o),
    .code_o   (ctrl_code_o)
  );
endmodule

// File: rtl/cal_center_loop_chk.sv
module cal_center_loop_chk #(
  parameter int CODE_W    = 8,
  parameter int FAST_STEP = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ofs_wr_i,
  input logic              loop_off_i,
  input logic [CODE_W-1:0] ctrl_code_o,
  input logic              fast_acq_o
);
  AST_WR_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_wr_i |=> fast_acq_o); // R7

  AST_WR_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_wr_i |=> $stable(ctrl_code_o)); // R9

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_off_i |=> $stable(ctrl_code_o)); // R8

  AST_SLOW_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_acq_o |=> (ctrl_code_o == $past(ctrl_code_o)) ||
                    ({1'b0, ctrl_code_o} == {1'b0, $past(ctrl_code_o)} + 1'b1) ||
                    ({1'b0, ctrl_code_o} + 1'b1 == {1'b0, $past(ctrl_code_o)})); // R5

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_acq_o |=> ((ctrl_code_o >= $past(ctrl_code_o)) ?
                    (int'(ctrl_code_o) - int'($past(ctrl_code_o)) <= FAST_STEP) :
                    (int'($past(ctrl_code_o)) - int'(ctrl_code_o) <= FAST_STEP))); // R2

  AST_FAST_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fast_acq_o) |-> !$past(ofs_wr_i)); // R3
endmodule

bind cal_center_loop cal_center_loop_chk #(
  .CODE_W   (CODE_W),
  .FAST_STEP(FAST_STEP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ofs_wr_i   (ofs_wr_i),
  .loop_off_i (loop_off_i),
  .ctrl_code_o(ctrl_code_o),
  .fast_acq_o (fast_acq_o)
);

// File: tb/sim_cal_center_loop.sv
`timescale 1ns/1ps
module sim_cal_center_loop;
  localparam int CODE_W = 8;
  localparam int INIT   = 128;
  localparam int FSTEP  = 4;
  localparam int OFS_W  = 9;
  localparam int NOM    = 40;
  localparam int WIN    = 2;
  localparam int DIV    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              wr = 1'b0;
  logic [OFS_W-1:0]  wdata = '0;
  logic              off = 1'b0;
  logic [CODE_W-1:0] code;
  logic              fast;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cal_center_loop #(
    .CODE_W(CODE_W), .CODE_INIT(INIT), .FAST_STEP(FSTEP), .OFS_W(OFS_W),
    .CNT_W(16), .NOM_COUNT(NOM), .WIN_PERIODS(WIN), .SLOW_DIV(DIV), .ACQ_UPDATES(64)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .ofs_wr_i(wr),
    .ofs_data_i(wdata), .loop_off_i(off), .ctrl_code_o(code), .fast_acq_o(fast)
  );

  task automatic check(input int exp_code, input bit exp_fast, input string req);
    checks++;
    if (int'(code) != exp_code || fast != exp_fast) begin
      errors++;
      $display("FAIL %s: code=%0d fast=%0b expected code=%0d fast=%0b",
               req, code, fast, exp_code, exp_fast);
    end
  endtask

  // strobe p cycles after the previous one
  task automatic strobe(input int p);
    repeat (p - 1) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic windows(input int n, input int p);
    for (int i = 0; i < n * WIN; i++) strobe(p);
  endtask

  task automatic write_ofs(input int v, input bit with_tick);
    wr = 1'b1; wdata = OFS_W'(v); tick = with_tick;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
  endtask

  function automatic int sat(input int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(INIT, 1, "R1 reset state");

    // count 2*25=50 > target 40: up
    strobe(5);
    windows(3, 25);
    check(INIT + 3 * FSTEP, 1, "R2 fast step up");
    windows(60, 25);
    check(sat(INIT + 63 * FSTEP), 1, "R4 max saturation, R3 still fast after 63");
    windows(1, 25);
    check(255, 0, "R3 fast ends after 64");

    // count 30 < 40: slow down
    windows(3, 15);
    check(255, 0, "R5 no step before divider");
    windows(1, 15);
    check(254, 0, "R5 unit step");
    windows(4, 15);
    check(253, 0, "R5 second unit step");

    // count 40 == 40
    windows(4, 20);
    check(253, 0, "R6 equal holds");

    // offset 10 -> target 50; count 44 now below target
    write_ofs(10, 0);
    check(253, 1, "R7 write restarts fast");
    strobe(5);
    windows(2, 22);
    check(253 - 2 * FSTEP, 1, "R7 offset shifts target");

    off = 1'b1;
    windows(3, 15);
    check(245, 1, "R8 loop off holds code");
    off = 1'b0;

    windows(30, 15);
    check(245 - 30 * FSTEP, 1, "R2 fast step down");
    windows(31, 15);
    check(1, 1, "R8 frozen budget still fast");
    windows(1, 15);
    check(0, 0, "R4 min saturation, R8 budget 62 after freeze");

    write_ofs(0, 0);
    strobe(5);
    windows(1, 25);
    check(4, 1, "R2 fast up from zero");
    strobe(25);
    repeat (24) @(negedge clk);
    write_ofs(0, 1);
    check(4, 1, "R9 write beats window close");
    strobe(5);
    windows(63, 25);
    check(255, 1, "R9 fresh 64 budget after collision");
    windows(1, 25);
    check(255, 0, "R3 fast ends after fresh 64");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule